// File: doc/BRIEF.md
# SDRAM Power-Up, Refresh and Bank Command Sequencer

This block is the command-sequencing core for a single rank of four-bank SDRAM addressed with 13 row bits, 11 column bits and 2 bank bits. Once reset is released it holds clock enable high and waits out the power-up interval. It then closes every bank and issues a series of auto-refresh commands. Last, it loads the mode word that carries CAS latency, burst ordering and burst length. From then on it is ready for traffic.

After start-up it keeps a steady refresh cadence from a free-running pacer. It also serves one burst at a time from a valid/ready request port. Each request becomes an activate, a read or write, and then either an explicit single-bank precharge or an auto-precharge flagged on address bit 10. All minimum intervals are given in nanoseconds and converted to whole clocks at elaboration, with any fraction rounded up. Data capture, check bits and self-refresh belong to other blocks.

Top module: `sdr_seq_top`

## Requirements
- R1: While reset is held, sd_cke is 0 and the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1). From the first clock after reset sd_cke is 1 and stays 1. No command other than NOP appears until at least ceil(INIT_NS/CLK_NS) clocks after reset is released.
- R2: The first command is a precharge (0,0,1,0) with sd_addr = 13'h0400, so bit 10 is high and all banks close. It is followed by INIT_REFS auto-refresh commands (0,0,0,1) with sd_ba and sd_addr at zero. The first refresh comes at least tRP clocks after the precharge, and each later one at least tRC clocks after the one before.
- R3: After the start-up refreshes comes one mode-register write (0,0,0,0) with sd_ba = 0. sd_addr[2:0] holds the burst length code (1→0, 2→1, 4→2, 8→3), sd_addr[3] is 1 for interleaved order, sd_addr[6:4] holds the CAS latency, and all other bits are 0. The next command comes no sooner than 2 clocks later.
- R4: req_ready never rises before init_done. init_done rises together with the mode-register write.
- R5: After start-up, auto-refresh is paced by floor(REFI_NS/CLK_NS) clocks. The spacing between refreshes exceeds that interval only by the length of one transaction in flight. Over an idle window of N intervals, N±1 refreshes occur.
- R6: When a request is granted (req_valid and req_ready high at a clock edge), an activate (0,0,1,1) follows with sd_ba = req_bank and sd_addr = req_row.
- R7: The column command is a read (0,1,0,1) or a write (0,1,0,0). It carries sd_ba = bank, sd_addr[9:0] = col[9:0], sd_addr[11] = col[10], sd_addr[10] = req_autopre and sd_addr[12] = 0. It appears exactly tRCD clocks after its activate.
- R8: A request without auto-precharge is closed by a precharge with sd_addr = 0 (bit 10 low) and sd_ba = the bank. That precharge comes at least tRAS clocks after the activate and at least BURST_LEN clocks after the column command. The next command comes at least tRP after the precharge, and the next activate at least tRC after the previous activate.
- R9: A request with auto-precharge gets no explicit precharge. The next activate comes at least BURST_LEN+CAS_LAT+tRP clocks after its column command.
- R10: When a refresh is due and a request is pending at the same time, the refresh is issued first. No command follows a refresh within tRC clocks.
- R11: Every nanosecond timing becomes ceil(ns/CLK_NS) clocks, with a minimum of 1. At CLK_NS=15 this gives tRCD=2, tRP=2, tRAS=4 and tRC=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A burst request is presented |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_autopre | input | 1 | Close the bank with auto-precharge |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row to open |
| req_col | input | 11 | Starting column |
| req_ready | output | 1 | Request accepted at this edge |
| init_done | output | 1 | Start-up sequence complete |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column/mode address |

## Verification
The hardest case to reach from the ports is a refresh falling due while a request is already waiting. The pacer runs freely and cannot be seen directly, so the bench keeps req_valid high through a long stream of back-to-back bursts that spans several refresh intervals. This guarantees several collisions. The bench counts the refreshes seen while req_valid was high, and checks the spacing from each of those refreshes to the activate that follows it. A separate idle window then checks the plain refresh cadence.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

    localparam int ROW_W  = 13;
    localparam int COL_W  = 11;
    localparam int BANK_W = 2;
    localparam int ADDR_W = 13;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef struct packed {
        sdr_cmd_e            cmd;
        logic [BANK_W-1:0]   ba;
        logic [ADDR_W-1:0]   addr;
    } sdr_bus_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_PWR,
        ST_IREF,
        ST_MRS,
        ST_IDLE,
        ST_COL,
        ST_PRE
    } seq_state_e;

    typedef struct packed {
        logic               wr;
        logic               ap;
        logic [BANK_W-1:0]  ba;
        logic [COL_W-1:0]   col;
    } pend_t;

    function automatic int ns_to_clk(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [ADDR_W-1:0] mode_word(input int cl, input int ilv, input int bl);
        logic [ADDR_W-1:0] w;
        logic [2:0]        code;
        case (bl)
            1:       code = 3'd0;
            2:       code = 3'd1;
            4:       code = 3'd2;
            default: code = 3'd3;
        endcase
        w      = '0;
        w[2:0] = code;
        w[3]   = (ilv != 0);
        w[6:4] = 3'(cl);
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] col, input logic ap);
        return {1'b0, col[10], ap, col[9:0]};
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
`timescale 1ns/1ps
module sdr_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R11
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdr_refresh_pacer.sv
`timescale 1ns/1ps
module sdr_refresh_pacer #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic due
);
    localparam int            CW   = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            due <= 1'b0;
        else
            due <= (due && !ack) || wrap;
    end

    // R5
    due_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (due && !ack) |=> due);

endmodule

// File: rtl/sdr_cmd_reg.sv
`timescale 1ns/1ps
module sdr_cmd_reg
    import sdr_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  sdr_bus_t            nxt,
    output sdr_bus_t            bus_q,
    output logic                cke,
    output logic                cs_n,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [BANK_W-1:0]   ba,
    output logic [ADDR_W-1:0]   addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= '{cmd: CMD_NOP, ba: '0, addr: '0};
            cke   <= 1'b0;
        end else begin
            bus_q <= nxt;
            cke   <= 1'b1;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = bus_q.cmd;
    assign ba   = bus_q.ba;
    assign addr = bus_q.addr;

    // R1
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

endmodule

// File: rtl/sdr_seq_top.sv
`timescale 1ns/1ps
module sdr_seq_top
    import sdr_seq_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int INIT_NS   = 200000,
    parameter int REFI_NS   = 7800,
    parameter int TRCD_NS   = 20,
    parameter int TRP_NS    = 20,
    parameter int TRAS_NS   = 50,
    parameter int TRC_NS    = 70,
    parameter int MRD_CLK   = 2,
    parameter int INIT_REFS = 8,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int BURST_ILV = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_autopre,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    output logic                 req_ready,
    output logic                 init_done,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ADDR_W-1:0]    sd_addr
);
    // Timing in clocks, rounded up
    localparam int INIT_C = ns_to_clk(INIT_NS, CLK_NS);
    localparam int TRCD_C = ns_to_clk(TRCD_NS, CLK_NS);
    localparam int TRP_C  = ns_to_clk(TRP_NS,  CLK_NS);
    localparam int TRAS_C = ns_to_clk(TRAS_NS, CLK_NS);
    localparam int TRC_C  = ns_to_clk(TRC_NS,  CLK_NS);
    // Refresh interval rounded down so pacing is never late
    localparam int REFI_C = (REFI_NS / CLK_NS < 1) ? 1 : REFI_NS / CLK_NS;
    // Wait after an auto-precharge column command
    localparam int AP_C   = max3(BURST_LEN + CAS_LAT + TRP_C, TRC_C - TRCD_C, TRAS_C - TRCD_C + TRP_C);
    // Earliest explicit precharge after activate (covers tRAS and tRC)
    localparam int RAS_C  = (TRAS_C > TRC_C - TRP_C) ? TRAS_C : TRC_C - TRP_C;

    localparam int TW = $clog2(max3(INIT_C, AP_C, max3(TRC_C, BURST_LEN, MRD_CLK)) + 1);
    localparam int RW = $clog2(RAS_C + 1);
    localparam int IW = $clog2(INIT_REFS + 1);

    localparam logic [TW-1:0] L_INIT = TW'(INIT_C - 1);
    localparam logic [TW-1:0] L_TRP  = TW'(TRP_C - 1);
    localparam logic [TW-1:0] L_TRC  = TW'(TRC_C - 1);
    localparam logic [TW-1:0] L_TRCD = TW'(TRCD_C - 1);
    localparam logic [TW-1:0] L_MRD  = TW'(MRD_CLK - 1);
    localparam logic [TW-1:0] L_AP   = TW'(AP_C - 1);
    localparam logic [TW-1:0] L_BL   = TW'(BURST_LEN - 1);
    localparam logic [RW-1:0] L_RAS  = RW'(RAS_C - 1);
    localparam logic [IW-1:0] LAST_IREF = IW'(INIT_REFS - 1);
    localparam logic [ADDR_W-1:0] MODE  = mode_word(CAS_LAT, BURST_ILV, BURST_LEN);

    seq_state_e      st, st_n;
    pend_t           pend, pend_n;
    logic [IW-1:0]   icnt, icnt_n;
    logic            done_n;
    sdr_bus_t        nxt, bus_q;
    logic            t_load, t_busy, r_load, r_busy;
    logic [TW-1:0]   t_val;
    logic            ref_due, ref_ack, grant;

    sdr_wait_timer #(.W(TW)) cmd_timer_i (
        .clk(clk), .rst(rst), .load(t_load), .val(t_val), .busy(t_busy)
    );

    sdr_wait_timer #(.W(RW)) ras_timer_i (
        .clk(clk), .rst(rst), .load(r_load), .val(L_RAS), .busy(r_busy)
    );

    sdr_refresh_pacer #(.PERIOD(REFI_C)) pacer_i (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .due(ref_due)
    );

    sdr_cmd_reg cmd_reg_i (
        .clk(clk), .rst(rst), .nxt(nxt), .bus_q(bus_q),
        .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
        .we_n(sd_we_n), .ba(sd_ba), .addr(sd_addr)
    );

    always_comb begin
        nxt     = '{cmd: CMD_NOP, ba: '0, addr: '0};
        st_n    = st;
        pend_n  = pend;
        icnt_n  = icnt;
        done_n  = init_done;
        t_load  = 1'b0;
        t_val   = '0;
        r_load  = 1'b0;
        ref_ack = 1'b0;
        grant   = 1'b0;
        case (st)
            ST_BOOT: begin
                t_load = 1'b1;
                t_val  = L_INIT;
                st_n   = ST_PWR;
            end
            ST_PWR: if (!t_busy) begin
                nxt.cmd      = CMD_PRE;
                nxt.addr[10] = 1'b1;
                t_load       = 1'b1;
                t_val        = L_TRP;
                icnt_n       = '0;
                st_n         = ST_IREF;
            end
            ST_IREF: if (!t_busy) begin
                nxt.cmd = CMD_REF;
                t_load  = 1'b1;
                t_val   = L_TRC;
                icnt_n  = icnt + 1'b1;
                if (icnt == LAST_IREF) st_n = ST_MRS;
            end
            ST_MRS: if (!t_busy) begin
                nxt.cmd  = CMD_MRS;
                nxt.addr = MODE;
                t_load   = 1'b1;
                t_val    = L_MRD;
                done_n   = 1'b1;
                st_n     = ST_IDLE;
            end
            ST_IDLE: if (!t_busy) begin
                if (ref_due) begin
                    nxt.cmd = CMD_REF;
                    t_load  = 1'b1;
                    t_val   = L_TRC;
                    ref_ack = 1'b1;
                end else if (req_valid) begin
                    nxt.cmd  = CMD_ACT;
                    nxt.ba   = req_bank;
                    nxt.addr = req_row;
                    grant    = 1'b1;
                    t_load   = 1'b1;
                    t_val    = L_TRCD;
                    r_load   = 1'b1;
                    pend_n   = '{wr: req_write, ap: req_autopre, ba: req_bank, col: req_col};
                    st_n     = ST_COL;
                end
            end
            ST_COL: if (!t_busy) begin
                nxt.cmd  = pend.wr ? CMD_WR : CMD_RD;
                nxt.ba   = pend.ba;
                nxt.addr = col_addr(pend.col, pend.ap);
                t_load   = 1'b1;
                t_val    = pend.ap ? L_AP : L_BL;
                st_n     = pend.ap ? ST_IDLE : ST_PRE;
            end
            ST_PRE: if (!t_busy && !r_busy) begin
                nxt.cmd = CMD_PRE;
                nxt.ba  = pend.ba;
                t_load  = 1'b1;
                t_val   = L_TRP;
                st_n    = ST_IDLE;
            end
            default: st_n = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_BOOT;
            pend      <= '0;
            icnt      <= '0;
            init_done <= 1'b0;
        end else begin
            st        <= st_n;
            pend      <= pend_n;
            icnt      <= icnt_n;
            init_done <= done_n;
        end
    end

    assign req_ready = grant;

    // R4
    grant_after_init_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> init_done);

    // R10
    refresh_first_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !t_busy && ref_due) |=> (bus_q.cmd == CMD_REF));

    // R8
    bank_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && bus_q.cmd == CMD_PRE) |-> !bus_q.addr[10]);

    // R2
    init_pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done && bus_q.cmd == CMD_PRE) |-> bus_q.addr[10]);

endmodule

// File: tb/sdr_seq_top_tb_top.sv
`timescale 1ns/1ps
module sdr_seq_top_tb_top;

    localparam int CLK_PERIOD = 15;
    localparam int INIT_NS    = 3000;
    localparam int REFI_NS    = 1500;
    // Expected clock counts at 15 ns, worked out by hand (ceil of ns/15)
    localparam int E_INIT  = 200;
    localparam int E_REFI  = 100;
    localparam int E_TRCD  = 2;
    localparam int E_TRP   = 2;
    localparam int E_TRAS  = 4;
    localparam int E_TRC   = 5;
    localparam int E_MRD   = 2;
    localparam int E_CL    = 3;
    localparam int E_BL    = 4;
    localparam int SLACK   = 24;
    // BL4 -> 010 on bits 2:0, interleave bit 3 = 1, CL3 -> 011 on bits 6:4
    localparam logic [12:0] E_MODE = 13'h03A;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [10:0] req_col = '0;
    logic        req_ready, init_done;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    sdr_seq_top #(
        .CLK_NS(CLK_PERIOD), .INIT_NS(INIT_NS), .REFI_NS(REFI_NS),
        .CAS_LAT(E_CL), .BURST_LEN(E_BL), .BURST_ILV(1)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_ready(req_ready), .init_done(init_done),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0, fails = 0;
    int   rel_cyc = 0;
    bit   reset_done = 0, first_seen = 0, mrs_seen = 0;
    int   prev_cyc = 0;
    logic [3:0] prev_cmd = C_NOP;
    bit   act_v = 0, col_v = 0, col_ap = 0;
    int   last_act = 0, last_col = 0, ref_base = 0;
    int   ref_cnt = 0, ref_load = 0, early_grant = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            C_ACT:        return "R6";
            C_RD, C_WR:   return "R7";
            C_PRE:        return mrs_seen ? "R8" : "R2";
            C_MRS:        return "R3";
            default:      return "R2";
        endcase
    endfunction

    // Monitor: pops expected commands and checks spacing
    always @(negedge clk) begin
        logic [3:0] c;
        int gap;
        exp_t e, got;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (reset_done && !init_done && req_ready) early_grant++;
        if (reset_done && c != C_NOP) begin
            gap = cyc - prev_cyc;
            if (!first_seen) begin
                first_seen = 1;
                check(cyc - rel_cyc >= E_INIT, "R1", "clocks before first command", cyc - rel_cyc, E_INIT);
                check(sd_cke == 1'b1, "R1", "cke at first command", sd_cke, 1);
            end else begin
                if (prev_cmd == C_REF)
                    check(gap >= E_TRC, mrs_seen ? "R10" : "R2", "gap after refresh", gap, E_TRC);
                if (prev_cmd == C_PRE)
                    check(gap >= E_TRP, mrs_seen ? "R8" : "R2", "gap after precharge", gap, E_TRP);
                if (prev_cmd == C_MRS)
                    check(gap >= E_MRD, "R3", "gap after mode write", gap, E_MRD);
            end
            case (c)
                C_ACT: begin
                    if (act_v)
                        check(cyc - last_act >= E_TRC, "R8", "activate to activate", cyc - last_act, E_TRC);
                    if (col_v && col_ap)
                        check(cyc - last_col >= E_BL + E_CL + E_TRP, "R9", "auto-precharge to activate",
                              cyc - last_col, E_BL + E_CL + E_TRP);
                    act_v = 1; last_act = cyc;
                end
                C_RD, C_WR: begin
                    // R11: exact rounded tRCD
                    check(cyc - last_act == E_TRCD, "R11", "activate to column", cyc - last_act, E_TRCD);
                    col_v = 1; last_col = cyc; col_ap = sd_addr[10];
                end
                C_PRE: if (mrs_seen) begin
                    check(cyc - last_act >= E_TRAS, "R8", "activate to precharge", cyc - last_act, E_TRAS);
                    check(cyc - last_col >= E_BL, "R8", "column to precharge", cyc - last_col, E_BL);
                end
                default: ;
            endcase
            if (c == C_REF && mrs_seen) begin
                check(cyc - ref_base <= E_REFI + SLACK, "R5", "refresh spacing", cyc - ref_base, E_REFI + SLACK);
                ref_base = cyc;
                ref_cnt++;
                if (req_valid) ref_load++;
            end else begin
                got = '{cmd: c, ba: sd_ba, addr: sd_addr};
                if (q.size() == 0) begin
                    check(0, tag_of(c), "unexpected command", got, 0);
                end else begin
                    e = q.pop_front();
                    check(got == e, tag_of(e.cmd), "command/bank/address", got, e);
                end
                if (c == C_MRS) begin
                    mrs_seen = 1;
                    ref_base = cyc;
                    check(init_done == 1'b1, "R4", "init_done with mode write", init_done, 1);
                end
            end
            prev_cmd = c;
            prev_cyc = cyc;
        end
    end

    // Driver: pushes the expected command sequence, then presents the request
    task automatic do_req(input bit wr, input bit ap, input logic [1:0] ba,
                          input logic [12:0] row, input logic [10:0] col);
        q.push_back('{cmd: C_ACT, ba: ba, addr: row});
        q.push_back('{cmd: (wr ? C_WR : C_RD), ba: ba, addr: {1'b0, col[10], ap, col[9:0]}});
        if (!ap) q.push_back('{cmd: C_PRE, ba: ba, addr: 13'h0000});
        @(negedge clk);
        req_write = wr; req_autopre = ap; req_bank = ba; req_row = row; req_col = col;
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R5", "watchdog expired", cyc, 150000);
        summary();
    end

    initial begin
        logic [31:0] lf;
        int n0;
        q.push_back('{cmd: C_PRE, ba: 2'd0, addr: 13'h0400});
        for (int i = 0; i < 8; i++) q.push_back('{cmd: C_REF, ba: 2'd0, addr: 13'h0000});
        q.push_back('{cmd: C_MRS, ba: 2'd0, addr: E_MODE});

        repeat (4) @(negedge clk);
        check(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "command in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(init_done == 1'b0, "R4", "init_done in reset", init_done, 0);
        rst = 1'b0;
        rel_cyc = cyc;
        reset_done = 1;
        repeat (3) @(negedge clk);
        check(sd_cke == 1'b1, "R1", "cke after reset", sd_cke, 1);

        // First request is raised during start-up and must wait (R4)
        do_req(1'b0, 1'b1, 2'd2, 13'h1ABC, 11'h155);
        check(early_grant == 0, "R4", "grants before init_done", early_grant, 0);
        do_req(1'b1, 1'b1, 2'd1, 13'h0001, 11'h7FF);
        do_req(1'b0, 1'b0, 2'd3, 13'h1FFF, 11'h400);
        do_req(1'b1, 1'b0, 2'd0, 13'h0000, 11'h003);

        // Back-to-back stream spanning several refresh intervals (R10)
        lf = 32'hACE1_2345;
        for (int k = 0; k < 48; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_req(lf[0], lf[1], lf[3:2], lf[16:4], lf[27:17]);
        end

        while (q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(ref_load >= 1, "R10", "refreshes taken while a request waited", ref_load, 1);

        // Idle window: cadence only (R5)
        n0 = ref_cnt;
        repeat (10 * E_REFI) @(negedge clk);
        check((ref_cnt - n0 >= 9) && (ref_cnt - n0 <= 11), "R5", "refreshes in 10 intervals",
              ref_cnt - n0, 10);
        check(q.size() == 0, "R6", "pending expected commands", q.size(), 0);
        summary();
    end

endmodule